// File: doc/BRIEF.md
# Serial NOR Flash Pin Controller with Software Override

This block owns the pins of a serial NOR flash: four data lines, chip select and the serial clock. Two sources can drive them. The first is a small hardware engine. It drops chip select, clocks a command byte out on the data-out line, captures a byte from the data-in line, and then releases chip select. Its serial clock comes from a divider that software can program. The second source is a software override. A dedicated mode register hands the pins to software. Software then toggles clock, chip select and data-out through a write-only register and reads the returned data bit through a read-only status register.

The data lines have fixed roles. dq[0] carries data toward the flash, dq[1] carries data from the flash, dq[2] is the write-protect line and dq[3] is the hold line. The hardware keeps write-protect and hold driven high in both modes, so software never has to manage them. Only single-bit transfers are supported. A mode change requested while the engine is mid-transfer takes effect only after that transfer finishes.

The divider has a fast path. A divider of 1 means a full-rate serial clock. A flip-flop cannot produce a clock at that ratio, so the block then forms the serial clock combinationally from the inverted system clock, gated by the engine's busy state.

Top module: `spi_pin_ctrl`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, hw_busy is 0, the override is inactive, the divider reads back 4 and the override register holds clock=0, chip select=1, data-out=0.
- R2: In every mode, dq_oe is 4'b1101 (dq[1] is an input and the other three lines are outputs), and dq_o[3] and dq_o[2] are both 1.
- R3: Register address 0 is the mode register. Writing bit 0 requests the override (1) or the engine (2'b0 means engine). A read returns bit 0 = requested mode and bit 1 = active mode. The active mode follows the request one cycle later when the engine is idle.
- R4: While the override is active, address 1 drives the pins: bit 0 is sclk, bit 1 is cs_n and bit 2 is dq_o[0]. They reach the pins one cycle after the write. Reading address 1 returns 0.
- R5: Address 2 bit 0 reads dq_i[1] combinationally, never dq_i[0]. Writes to address 2 have no effect.
- R6: A hw_start pulse with the engine selected and idle starts a transfer. cs_n is 0 exactly while hw_busy is 1. Eight hw_cmd bits go out MSB first on dq_o[0]; each bit is valid at every rising sclk. dq_i[1] is captured at each rising sclk. When the transfer finishes, the captured byte appears on hw_rdata, hw_done pulses for one cycle and hw_busy falls.
- R7: For a divider N of 2 or more, each bit lasts N cycles, with sclk low for N-N/2 cycles and then high for N/2 cycles (integer division). hw_busy lasts 8N cycles. A bit is shifted out at a falling sclk and sampled at a rising one, never both in the same cycle.
- R8: For a divider of 1, sclk equals the inverted system clock while hw_busy is 1 and 0 otherwise, and the transfer lasts 8 cycles.
- R9: A write to the mode register during a transfer leaves the pins with the engine until hw_busy falls. The transfer completes unchanged.
- R10: hw_start is ignored while the override is active or a transfer is running. hw_busy stays 0 in the first case, and the running transfer keeps its length in the second.
- R11: Address 3 is the divider. Writing 0 leaves it unchanged. A transfer uses the divider value captured at its start, even if the divider is rewritten mid-transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hw_start | input | 1 | Start pulse for the hardware engine |
| hw_cmd | input | 8 | Command byte to send |
| hw_rdata | output | 8 | Byte captured in the last transfer |
| hw_busy | output | 1 | Engine transfer in progress |
| hw_done | output | 1 | One-cycle pulse at transfer end |
| dq_i | input | 4 | Data pin input values |
| dq_o | output | 4 | Data pin output values |
| dq_oe | output | 4 | Data pin output enables |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |

## Verification
The assertions check the following on every cycle:
- the fixed pin directions and the high write-protect and hold lines;
- chip select tracking the busy flag;
- the mode being frozen while a transfer runs;
- blocking of starts in override mode;
- the single-cycle done pulse;
- shift and sample events never coinciding above divide-by-one.

Only the bench scenarios can show the rest. These include the serial order of the bits seen by a flash model, the sclk duty cycle and transfer length for each divider, the full-rate combinational clock, and the deferred mode switch. They also cover the divider latch and the register readback that proves writes to the status and override registers were ignored or took effect.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    ADDR_MODE  = 2'd0,
    ADDR_BBOUT = 2'd1,
    ADDR_BBIN  = 2'd2,
    ADDR_DIV   = 2'd3
  } reg_addr_e;

  // bit positions inside the override output register
  localparam int BB_SCLK = 0;
  localparam int BB_CSN  = 1;
  localparam int BB_MOSI = 2;
  localparam logic [2:0] BB_RESET = 3'b010;

  // dq0 out (data to flash), dq1 in, dq2/dq3 out held high
  localparam logic [3:0] DQ_OE_PATTERN = 4'b1101;

  // number of low-phase cycles in one serial bit for divider n
  function automatic logic [31:0] low_phase_len(input logic [31:0] n);
    return n - (n >> 1);
  endfunction

  // number of high-phase cycles in one serial bit for divider n
  function automatic logic [31:0] high_phase_len(input logic [31:0] n);
    return n >> 1;
  endfunction
endpackage

// File: rtl/spi_pin_regs.sv
module spi_pin_regs
  import spi_pin_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int RESET_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             miso_in,
  input  logic             hold_mode,
  output logic             bb_active,
  output logic [2:0]       bb_pins,
  output logic [DIV_W-1:0] div_val
);
  logic             mode_req_q;
  logic             mode_act_q;
  logic [2:0]       bb_q;
  logic [DIV_W-1:0] div_q;
  logic             div_wr_ok;

  assign div_wr_ok = (reg_wdata[DIV_W-1:0] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_req_q <= 1'b0;
      mode_act_q <= 1'b0;
      bb_q       <= BB_RESET;
      div_q      <= DIV_W'(RESET_DIV);
    end else begin
      if (reg_we) begin
        case (reg_addr_e'(reg_addr))
          ADDR_MODE:  mode_req_q <= reg_wdata[0];
          ADDR_BBOUT: bb_q       <= reg_wdata[2:0];
          ADDR_DIV:   if (div_wr_ok) div_q <= reg_wdata[DIV_W-1:0];
          default:    ;
        endcase
      end
      // the mode may only move while the engine is idle and not being started
      if (!hold_mode) mode_act_q <= mode_req_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr_e'(reg_addr))
      ADDR_MODE:  reg_rdata = {{(REG_W-2){1'b0}}, mode_act_q, mode_req_q};
      ADDR_BBOUT: reg_rdata = '0;
      ADDR_BBIN:  reg_rdata = {{(REG_W-1){1'b0}}, miso_in};
      ADDR_DIV:   reg_rdata = REG_W'(div_q);
      default:    reg_rdata = '0;
    endcase
  end

  assign bb_active = mode_act_q;
  assign bb_pins   = bb_q;
  assign div_val   = div_q;
endmodule

// File: rtl/spi_pin_engine.sv
module spi_pin_engine
  import spi_pin_pkg::*;
#(
  parameter int XFER_BITS = 8,
  parameter int DIV_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [XFER_BITS-1:0] cmd,
  input  logic [DIV_W-1:0]     div_val,
  input  logic                 miso,
  output logic                 busy,
  output logic                 done,
  output logic [XFER_BITS-1:0] rdata,
  output logic                 mosi,
  output logic                 sclk_reg,
  output logic                 div1,
  output logic                 sample_evt,
  output logic                 shift_evt
);
  localparam int CNT_W = (XFER_BITS > 1) ? $clog2(XFER_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(XFER_BITS - 1);

  logic                 busy_q, done_q, sclk_q;
  logic [DIV_W-1:0]     ph_q, div_l, lo_l;
  logic [CNT_W-1:0]     bit_q;
  logic [XFER_BITS-1:0] sh_q, rx_q, rd_q;

  logic                 last_ph, last_bit;
  logic                 busy_nxt, sclk_nxt;
  logic [DIV_W-1:0]     ph_nxt;
  logic [XFER_BITS-1:0] rx_nxt;

  assign div1       = (div_l == DIV_W'(1));
  assign last_ph    = (ph_q == div_l - 1'b1);
  assign last_bit   = (bit_q == LAST_BIT);
  assign sample_evt = busy_q && (div1 || (ph_q == lo_l - 1'b1));
  assign shift_evt  = busy_q && last_ph;
  assign rx_nxt     = sample_evt ? {rx_q[XFER_BITS-2:0], miso} : rx_q;

  always_comb begin
    busy_nxt = busy_q;
    ph_nxt   = ph_q;
    if (go) begin
      busy_nxt = 1'b1;
      ph_nxt   = '0;
    end else if (busy_q) begin
      if (last_ph) begin
        ph_nxt = '0;
        if (last_bit) busy_nxt = 1'b0;
      end else begin
        ph_nxt = ph_q + 1'b1;
      end
    end
    sclk_nxt = busy_nxt && !go && (ph_nxt >= lo_l);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      ph_q   <= '0;
      div_l  <= DIV_W'(1);
      lo_l   <= DIV_W'(1);
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_nxt;
      ph_q   <= ph_nxt;
      sclk_q <= sclk_nxt;
      done_q <= shift_evt && last_bit;
      if (go) begin
        div_l <= div_val;
        lo_l  <= DIV_W'(low_phase_len(32'(div_val)));
        sh_q  <= cmd;
        bit_q <= '0;
        rx_q  <= '0;
      end else begin
        rx_q <= rx_nxt;
        if (shift_evt) begin
          if (last_bit) begin
            rd_q <= rx_nxt;
          end else begin
            sh_q  <= {sh_q[XFER_BITS-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rdata    = rd_q;
  assign mosi     = sh_q[XFER_BITS-1];
  assign sclk_reg = sclk_q;
endmodule

// File: rtl/spi_pin_mux.sv
module spi_pin_mux
  import spi_pin_pkg::*;
(
  input  logic       clk,
  input  logic       bb_active,
  input  logic [2:0] bb_pins,
  input  logic       eng_busy,
  input  logic       eng_mosi,
  input  logic       eng_sclk_reg,
  input  logic       eng_div1,
  output logic       cs_n,
  output logic       sclk,
  output logic [3:0] dq_o,
  output logic [3:0] dq_oe
);
  logic hw_sclk;

  // full rate cannot come from a flop: pass the inverted clock through a gate
  assign hw_sclk = eng_div1 ? (eng_busy & ~clk) : eng_sclk_reg;

  assign sclk  = bb_active ? bb_pins[BB_SCLK] : hw_sclk;
  assign cs_n  = bb_active ? bb_pins[BB_CSN]  : ~eng_busy;
  assign dq_o  = {2'b11, 1'b0, (bb_active ? bb_pins[BB_MOSI] : eng_mosi)};
  assign dq_oe = DQ_OE_PATTERN;
endmodule

// File: rtl/spi_pin_ctrl.sv
module spi_pin_ctrl
  import spi_pin_pkg::*;
#(
  parameter int XFER_BITS = 8,
  parameter int DIV_W     = 8,
  parameter int RESET_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_we,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 hw_start,
  input  logic [XFER_BITS-1:0] hw_cmd,
  output logic [XFER_BITS-1:0] hw_rdata,
  output logic                 hw_busy,
  output logic                 hw_done,
  input  logic [3:0]           dq_i,
  output logic [3:0]           dq_o,
  output logic [3:0]           dq_oe,
  output logic                 cs_n,
  output logic                 sclk
);
  logic             bb_active;
  logic [2:0]       bb_pins;
  logic [DIV_W-1:0] div_val;
  logic             accept, hold_mode;
  logic             eng_busy, eng_mosi, eng_sclk_reg, eng_div1;
  logic             sample_evt, shift_evt;
  logic             miso;

  assign miso      = dq_i[1];
  assign accept    = hw_start && !bb_active && !eng_busy;
  assign hold_mode = eng_busy || accept;

  spi_pin_regs #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .miso_in(miso),
    .hold_mode(hold_mode), .bb_active(bb_active), .bb_pins(bb_pins),
    .div_val(div_val)
  );

  spi_pin_engine #(.XFER_BITS(XFER_BITS), .DIV_W(DIV_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .go(accept), .cmd(hw_cmd), .div_val(div_val),
    .miso(miso), .busy(eng_busy), .done(hw_done), .rdata(hw_rdata),
    .mosi(eng_mosi), .sclk_reg(eng_sclk_reg), .div1(eng_div1),
    .sample_evt(sample_evt), .shift_evt(shift_evt)
  );

  spi_pin_mux u_mux (
    .clk(clk), .bb_active(bb_active), .bb_pins(bb_pins), .eng_busy(eng_busy),
    .eng_mosi(eng_mosi), .eng_sclk_reg(eng_sclk_reg), .eng_div1(eng_div1),
    .cs_n(cs_n), .sclk(sclk), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  assign hw_busy = eng_busy;
endmodule

// File: rtl/spi_pin_ctrl_chk.sv
module spi_pin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bb_active,
  input logic       accept,
  input logic       hw_start,
  input logic       hw_busy,
  input logic       hw_done,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] dq_o,
  input logic [3:0] dq_oe,
  input logic       eng_div1,
  input logic       sample_evt,
  input logic       shift_evt
);
  assert_pin_roles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'b1101) && (dq_o[3:2] == 2'b11));

  assert_cs_tracks_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_busy |-> (!cs_n && !bb_active));

  assert_idle_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bb_active && !hw_busy) |-> (cs_n && !sclk));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_done |-> (!hw_busy && $past(hw_busy)));

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_busy |=> $stable(bb_active));

  assert_start_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_start && bb_active) |=> !hw_busy);

  assert_start_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (hw_busy && !bb_active));

  assert_events_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && shift_evt) |-> eng_div1);
endmodule

bind spi_pin_ctrl spi_pin_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bb_active(bb_active), .accept(accept),
  .hw_start(hw_start), .hw_busy(hw_busy), .hw_done(hw_done), .cs_n(cs_n),
  .sclk(sclk), .dq_o(dq_o), .dq_oe(dq_oe), .eng_div1(eng_div1),
  .sample_evt(sample_evt), .shift_evt(shift_evt)
);

// File: tb/spi_pin_ctrl_bench.sv
`timescale 1ns/1ps
module spi_pin_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       hw_start = 1'b0;
  logic [7:0] hw_cmd = '0;
  logic [7:0] hw_rdata;
  logic       hw_busy, hw_done;
  logic [3:0] dq_i, dq_o, dq_oe;
  logic       cs_n, sclk;

  int nvec = 0;
  int nerr = 0;

  // flash model state
  logic       model_on = 1'b0;
  logic [7:0] m_pat = '0;
  logic [7:0] m_cap = '0;
  int         m_idx = 0;
  int         m_rise = 0;
  logic       flash_bit = 1'b0;
  logic       use_tb = 1'b1;
  logic       tb_miso = 1'b0;
  logic       tb_dq0 = 1'b0;

  assign dq_i = {2'b00, (use_tb ? tb_miso : flash_bit), tb_dq0};

  always #10 clk = ~clk;

  spi_pin_ctrl u_spi_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_start(hw_start),
    .hw_cmd(hw_cmd), .hw_rdata(hw_rdata), .hw_busy(hw_busy), .hw_done(hw_done),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .cs_n(cs_n), .sclk(sclk)
  );

  always @(posedge sclk) if (model_on) begin
    m_cap  = {m_cap[6:0], dq_o[0]};
    m_rise = m_rise + 1;
  end

  always @(negedge sclk) if (model_on) begin
    #1;
    m_idx = m_idx + 1;
    if (m_idx < 8) flash_bit = m_pat[7 - m_idx];
  end

  function automatic int exp_busy(input int n);
    return 8 * n;
  endfunction

  function automatic int exp_high(input int n);
    return (n == 1) ? 8 : 8 * (n / 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  // twist: 0 none, 1 mode write mid-transfer, 2 second start, 3 divider rewrite
  task automatic xfer(input int n, input logic [7:0] cmd, input logic [7:0] pat, input int twist);
    int busy_cnt, high_cnt;
    logic [7:0] v;
    wr(2'd3, 8'(n));
    use_tb = 1'b0; m_pat = pat; m_idx = 0; m_rise = 0; m_cap = '0;
    flash_bit = pat[7]; model_on = 1'b1;
    @(negedge clk);
    hw_start = 1'b1; hw_cmd = cmd;
    @(negedge clk);
    hw_start = 1'b0;
    busy_cnt = 0; high_cnt = 0;
    fork
      begin
        while (hw_busy && busy_cnt < 5000) begin
          busy_cnt++;
          if (sclk) high_cnt++;
          @(negedge clk);
        end
      end
      begin
        if (twist != 0) begin
          @(negedge clk);
          if (twist == 1) begin
            reg_addr = 2'd0; reg_wdata = 8'h01; reg_we = 1'b1;
            @(negedge clk);
            reg_we = 1'b0;
            #1 v = reg_rdata;
            chk("R9 mode read mid-transfer", 32'(v), 32'h01);
          end else if (twist == 2) begin
            hw_start = 1'b1; hw_cmd = ~cmd;
            @(negedge clk);
            hw_start = 1'b0;
          end else begin
            reg_addr = 2'd3; reg_wdata = 8'(n + 2); reg_we = 1'b1;
            @(negedge clk);
            reg_we = 1'b0;
          end
        end
      end
    join
    chk("R6 done pulse", 32'(hw_done), 32'h1);
    chk("R6 captured byte", 32'(hw_rdata), 32'(pat));
    chk("R6 command on dq0", 32'(m_cap), 32'(cmd));
    chk("R6 rising edges", 32'(m_rise), 32'd8);
    chk((n == 1) ? "R8 length" : "R7 length", 32'(busy_cnt), 32'(exp_busy(n)));
    chk((n == 1) ? "R8 sclk high" : "R7 sclk high", 32'(high_cnt), 32'(exp_high(n)));
    chk("R6 cs released", 32'(cs_n), 32'h1);
    model_on = 1'b0; use_tb = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", 32'(cs_n), 32'h1);
    chk("R1 sclk", 32'(sclk), 32'h0);
    chk("R1 busy", 32'(hw_busy), 32'h0);
    rd(2'd0, v); chk("R1 mode", 32'(v), 32'h0);
    rd(2'd3, v); chk("R1 divider", 32'(v), 32'h4);
    // R2 pin roles
    chk("R2 oe", 32'(dq_oe), 32'hd);
    chk("R2 wp/hold", 32'(dq_o[3:2]), 32'h3);

    // R5 status from dq1 only
    tb_dq0 = 1'b1; tb_miso = 1'b0;
    rd(2'd2, v); chk("R5 dq0 not used", 32'(v), 32'h0);
    tb_dq0 = 1'b0; tb_miso = 1'b1;
    rd(2'd2, v); chk("R5 dq1 read", 32'(v), 32'h1);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R5 write ignored", 32'(v), 32'h1);

    // R11 zero divider write ignored
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R11 zero ignored", 32'(v), 32'h4);
    wr(2'd3, 8'h05);
    rd(2'd3, v); chk("R11 divider set", 32'(v), 32'h5);

    // directed transfers: full rate, even and odd dividers
    xfer(1, 8'hA5, 8'h3C, 0);
    xfer(2, 8'h81, 8'h7E, 0);
    xfer(5, 8'h05, 8'hC3, 0);
    // random transfers
    for (int i = 0; i < 12; i++) begin
      xfer(1 + int'($urandom % 6), 8'($urandom), 8'($urandom), 0);
    end

    // R11 divider latched at start
    xfer(3, 8'h9F, 8'h12, 3);
    rd(2'd3, v); chk("R11 new divider kept", 32'(v), 32'h5);
    // R10 second start while busy ignored
    xfer(4, 8'h0B, 8'hF0, 2);
    chk("R10 no restart", 32'(hw_busy), 32'h0);
    // R9 deferred mode switch
    xfer(4, 8'h66, 8'h99, 1);
    rd(2'd0, v); chk("R9 mode applied after", 32'(v), 32'h3);
    chk("R2 oe in override", 32'(dq_oe), 32'hd);
    chk("R2 wp/hold in override", 32'(dq_o[3:2]), 32'h3);

    // R4 override pins
    wr(2'd1, 8'h05);
    chk("R4 sclk", 32'(sclk), 32'h1);
    chk("R4 cs_n", 32'(cs_n), 32'h0);
    chk("R4 mosi", 32'(dq_o[0]), 32'h1);
    rd(2'd1, v); chk("R4 write-only", 32'(v), 32'h0);
    wr(2'd1, 8'h02);
    chk("R4 sclk low", 32'(sclk), 32'h0);
    chk("R4 cs_n high", 32'(cs_n), 32'h1);
    chk("R4 mosi low", 32'(dq_o[0]), 32'h0);

    // R10 start blocked in override
    @(negedge clk); hw_start = 1'b1; hw_cmd = 8'hFF;
    @(negedge clk); hw_start = 1'b0;
    chk("R10 busy stays low", 32'(hw_busy), 32'h0);
    chk("R10 cs from override", 32'(cs_n), 32'h1);
    tb_miso = 1'b1;
    rd(2'd2, v); chk("R5 status in override", 32'(v), 32'h1);

    // R3 back to engine
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R3 mode engine", 32'(v), 32'h0);
    xfer(2, 8'h3A, 8'h5B, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule